// File: doc/BRIEF.md
# CMI Line Decoder with Violation Flag

This block turns a stream of coded-mark-inversion half-bit samples, one sample per clock at twice the bit rate, back into NRZ data. Each decoded bit leaves on a one-clock strobe, together with a flag that marks a bit breaking the line-code rules. The decoder finds the bit boundary from the received signal alone. It counts how often a high-then-low half-bit pair appears under the current pairing. When that count is too high, it moves the pairing by one half-bit.

A mode input bypasses decoding, so each clock's sample is taken as one NRZ bit and passed through with the same fixed delay. A loss-of-signal input holds the decoded data low. Sampling and clock recovery happen upstream: the block sees already-retimed samples.

Top module: `cmi_line_decoder`

## Requirements
- R1: A half-bit pair of low then high (first sample 0, second sample 1) decodes to data 0 with the flag low.
- R2: A pair of equal halves decodes to data 1. Consecutive ones whose levels alternate (00 then 11 or 11 then 00) raise no flag.
- R3: A half-bit pair of high then low (first 1, second 0) decodes to data 0 with the flag high for that bit only.
- R4: A one whose level equals the level of the previous one is flagged. The tracked level then takes the level of this violating one, so the next properly alternating one is not flagged.
- R5: The first one after reset, after leaving bypass mode, or after a realignment is never flagged. It only seeds the tracked level, including when that one is the pair that triggers the realignment.
- R6: `dec_valid`, `dec_data` and `dec_viol` change together. They carry a bit in the clock that follows the fourth rising edge counted from, and including, the edge that samples the bit's second half. `dec_viol` is never high without `dec_valid`.
- R7: Completed pairs are grouped into windows of 16. If more than 2 high-then-low pairs fall in one window, the phase is held for one clock, so the next sample completes a pair at once and the pairing moves one half-bit earlier. Both counts then restart.
- R8: With `nrz_mode` high, every clock is one bit. `line_in` appears on `dec_data` with the R6 delay, `dec_valid` is high and `dec_viol` is low. Pairing, window counts and the level tracker are cleared.
- R9: On each rising edge where `los` is high, `dec_data` is driven low. `dec_valid` and `dec_viol` are not affected.
- R10: Synchronous active-high reset clears all outputs. The first sample after reset is the first half of a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| nrz_mode | input | 1 | High selects bypass: one sample per bit, no decoding |
| los | input | 1 | Loss of signal; forces decoded data low |
| line_in | input | 1 | Retimed line sample, one per clock |
| dec_valid | output | 1 | One-clock strobe per decoded bit |
| dec_data | output | 1 | Decoded NRZ bit |
| dec_viol | output | 1 | Line-code violation on the current bit |

## Verification
The bench drives the decoder from an encoder model that alternates the level of its ones. It injects both kinds of violation and checks that each flag lands on the exact bit that carries it. A tracker that kept the expected level instead of the received one would flag the clean one after each injected violation.

The bench also starts a stream one half-bit late. A decoder that slipped the wrong way, or never slipped, would keep flagging illegal zeros well after the first window. It also switches between bypass and coded modes. A decoder that kept its level tracker across the switch would flag the first one afterwards.

Loss of signal is raised during live traffic. A design that gated the strobe or masked too late would show ones in the clock after `los` is sampled high.

// File: rtl/cmi_dec_pkg.sv
package cmi_dec_pkg;
  typedef struct packed {
    logic valid;
    logic data;
    logic viol;
  } nrz_sym_t;
endpackage

// File: rtl/cmi_pair_phase.sv
module cmi_pair_phase #(
  parameter int WIN_PAIRS   = 16,
  parameter int SLIP_THRESH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic nrz_mode,
  input  logic line_in,
  output logic pair_done,
  output logic first_half,
  output logic slip
);
  localparam int WIN_W = (WIN_PAIRS > 1) ? $clog2(WIN_PAIRS) : 1;
  localparam int HL_W  = $clog2(WIN_PAIRS + 1);

  logic             ph;
  logic             prev;
  logic [WIN_W-1:0] win_cnt;
  logic [HL_W-1:0]  hl_cnt;
  logic [HL_W:0]    hl_sum;
  logic             is_hl;
  logic             win_last;

  assign pair_done  = !nrz_mode && ph;
  assign first_half = prev;
  assign is_hl      = pair_done && prev && !line_in;
  assign win_last   = (win_cnt == WIN_W'(WIN_PAIRS - 1));
  assign hl_sum     = {1'b0, hl_cnt} + {{HL_W{1'b0}}, is_hl};
  assign slip       = pair_done && win_last && (hl_sum > (HL_W+1)'(SLIP_THRESH));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
    end else begin
      prev <= line_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || nrz_mode) begin
      ph      <= 1'b0;
      win_cnt <= '0;
      hl_cnt  <= '0;
    end else if (ph) begin
      ph <= slip;
      if (win_last) begin
        win_cnt <= '0;
        hl_cnt  <= '0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
        hl_cnt  <= hl_sum[HL_W-1:0];
      end
    end else begin
      ph <= 1'b1;
    end
  end

  AST_SLIP_HOLDS_PHASE: assert property (@(posedge clk) disable iff (rst)
    slip |=> (pair_done || nrz_mode)); // R7

  AST_NO_PAIR_IN_BYPASS: assert property (@(posedge clk) disable iff (rst)
    nrz_mode |-> !pair_done); // R8
endmodule

// File: rtl/cmi_symbol_decode.sv
module cmi_symbol_decode
  import cmi_dec_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     nrz_mode,
  input  logic     line_in,
  input  logic     pair_done,
  input  logic     first_half,
  input  logic     slip,
  output nrz_sym_t sym
);
  logic     seeded;
  logic     lvl;
  nrz_sym_t sym_n;

  always_comb begin
    sym_n = '0;
    if (nrz_mode) begin
      sym_n = '{valid: 1'b1, data: line_in, viol: 1'b0};
    end else if (pair_done) begin
      unique case ({first_half, line_in})
        2'b10:   sym_n = '{valid: 1'b1, data: 1'b0, viol: 1'b1};
        2'b01:   sym_n = '{valid: 1'b1, data: 1'b0, viol: 1'b0};
        default: sym_n = '{valid: 1'b1, data: 1'b1, viol: seeded && (lvl == line_in)};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym    <= '0;
      seeded <= 1'b0;
      lvl    <= 1'b0;
    end else begin
      sym <= sym_n;
      if (nrz_mode) begin
        seeded <= 1'b0;
      end else if (pair_done) begin
        if (first_half == line_in) begin
          lvl <= line_in;
        end
        if (slip) begin
          seeded <= 1'b0;
        end else if (first_half == line_in) begin
          seeded <= 1'b1;
        end
      end
    end
  end

  AST_ILLEGAL_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (pair_done && first_half && !line_in) |=> (sym.viol && !sym.data)); // R3

  AST_FIRST_ONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (pair_done && !seeded && (first_half == line_in)) |=> !sym.viol); // R5

  AST_BYPASS_FLAG_LOW: assert property (@(posedge clk) disable iff (rst)
    nrz_mode |=> (sym.valid && !sym.viol)); // R8
endmodule

// File: rtl/cmi_out_pipe.sv
module cmi_out_pipe
  import cmi_dec_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     los,
  input  nrz_sym_t sym_in,
  output nrz_sym_t sym_out
);
  nrz_sym_t stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    nrz_sym_t src;
    if (i == 0) begin : g_src_in
      assign src = sym_in;
    end else begin : g_src_prev
      assign src = stage[i-1];
    end

    if (i == DEPTH - 1) begin : g_masked
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= '{valid: src.valid, data: src.data && !los, viol: src.viol};
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= src;
      end
    end
  end

  assign sym_out = stage[DEPTH-1];

  AST_LOS_DATA_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(los) |-> !sym_out.data); // R9

  AST_FLAG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    sym_out.viol |-> sym_out.valid); // R6
endmodule

// File: rtl/cmi_line_decoder.sv
module cmi_line_decoder
  import cmi_dec_pkg::*;
#(
  parameter int WIN_PAIRS   = 16,
  parameter int SLIP_THRESH = 2,
  parameter int LATENCY     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic nrz_mode,
  input  logic los,
  input  logic line_in,
  output logic dec_valid,
  output logic dec_data,
  output logic dec_viol
);
  localparam int PIPE_DEPTH = (LATENCY > 1) ? LATENCY - 1 : 1;

  logic     pair_done;
  logic     first_half;
  logic     slip;
  nrz_sym_t sym_s1;
  nrz_sym_t sym_out;

  cmi_pair_phase #(
    .WIN_PAIRS  (WIN_PAIRS),
    .SLIP_THRESH(SLIP_THRESH)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .nrz_mode  (nrz_mode),
    .line_in   (line_in),
    .pair_done (pair_done),
    .first_half(first_half),
    .slip      (slip)
  );

  cmi_symbol_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .nrz_mode  (nrz_mode),
    .line_in   (line_in),
    .pair_done (pair_done),
    .first_half(first_half),
    .slip      (slip),
    .sym       (sym_s1)
  );

  cmi_out_pipe #(
    .DEPTH(PIPE_DEPTH)
  ) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .los    (los),
    .sym_in (sym_s1),
    .sym_out(sym_out)
  );

  assign dec_valid = sym_out.valid;
  assign dec_data  = sym_out.data;
  assign dec_viol  = sym_out.viol;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !(dec_valid || dec_data || dec_viol)); // R10
endmodule

// File: tb/cmi_line_decoder_test.sv
module cmi_line_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 16;
  localparam int THR        = 2;
  localparam int LAT        = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nrz_mode = 1'b0;
  logic los = 1'b0;
  logic line_in = 1'b0;
  logic dec_valid, dec_data, dec_viol;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    cmp_en = 0;
  string cur_req = "R10";

  cmi_line_decoder #(.WIN_PAIRS(WIN), .SLIP_THRESH(THR), .LATENCY(LAT)) uut (
    .clk(clk), .rst(rst), .nrz_mode(nrz_mode), .los(los), .line_in(line_in),
    .dec_valid(dec_valid), .dec_data(dec_data), .dec_viol(dec_viol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: {valid,data,viol} words through a delay queue
  logic [2:0] q[$];
  logic [2:0] exp_o = 3'b000;
  int m_ph = 0, m_prev = 0, m_seed = 0, m_lvl = 0, m_win = 0, m_hl = 0;

  always @(posedge clk) begin
    logic [2:0] s;
    int slipped;
    cyc++;
    slipped = 0;
    if (rst) begin
      q.delete();
      m_ph = 0; m_prev = 0; m_seed = 0; m_lvl = 0; m_win = 0; m_hl = 0;
      exp_o = 3'b000;
      cmp_en = 1;
    end else begin
      s = 3'b000;
      if (nrz_mode) begin
        s = {1'b1, line_in, 1'b0};
        m_ph = 0; m_seed = 0; m_win = 0; m_hl = 0;
      end else if (m_ph == 0) begin
        m_ph = 1;
      end else begin
        int hl;
        hl = (m_prev == 1 && line_in == 0) ? 1 : 0;
        if (m_prev == 1 && line_in == 0)      s = 3'b101;
        else if (m_prev == 0 && line_in == 1) s = 3'b100;
        else begin
          s = {1'b1, 1'b1, (m_seed == 1 && m_lvl == int'(line_in)) ? 1'b1 : 1'b0};
          m_lvl = int'(line_in);
          m_seed = 1;
        end
        if (m_win == WIN - 1) begin
          if (m_hl + hl > THR) slipped = 1;
          m_win = 0; m_hl = 0;
        end else begin
          m_win++; m_hl += hl;
        end
        if (slipped == 1) begin
          m_seed = 0;
          m_ph = 1;
        end else begin
          m_ph = 0;
        end
      end
      m_prev = int'(line_in);
      q.push_back(s);
      if (q.size() > LAT) void'(q.pop_front());
      exp_o = (q.size() == LAT) ? q[0] : 3'b000;
      if (los) exp_o[1] = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if ({dec_valid, dec_data, dec_viol} !== exp_o) begin
        fails++;
        $display("FAIL %s at cycle %0d: valid/data/viol got %b%b%b expected %b", cur_req, cyc,
                 dec_valid, dec_data, dec_viol, exp_o);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // encoder state
  logic enc_lvl = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic half(input logic v);
    line_in = v;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic bad);
    if (!b) begin
      if (bad) begin half(1'b1); half(1'b0); end
      else     begin half(1'b0); half(1'b1); end
    end else begin
      if (!bad) enc_lvl = ~enc_lvl;
      half(enc_lvl); half(enc_lvl);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({dec_valid, dec_data, dec_viol} !== 3'b000) begin
      fails++;
      $display("FAIL R10 reset: got %b%b%b expected 000", dec_valid, dec_data, dec_viol);
    end
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R10 R5";
    do_reset();
    // first ones after reset must not be flagged: same level as encoder start
    half(1'b0); half(1'b0);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);

    cur_req = "R1 R2 R6";
    for (int i = 0; i < 200; i++) send_bit(next_bit(), 1'b0);
    repeat (16) send_bit(1'b1, 1'b0);
    repeat (16) send_bit(1'b0, 1'b0);

    cur_req = "R3 R4";
    for (int i = 0; i < 300; i++) begin
      logic b;
      b = next_bit();
      send_bit(b, (i % 23) == 7);
    end
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b1); send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b0);

    cur_req = "R7 R5";
    half(1'b1);
    for (int i = 0; i < 120; i++) send_bit((i % 5) == 4, 1'b0);
    for (int i = 0; i < 100; i++) send_bit(next_bit(), 1'b0);

    cur_req = "R9";
    los = 1'b1;
    for (int i = 0; i < 60; i++) send_bit(next_bit(), (i % 17) == 3);
    los = 1'b0;
    for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b0);

    cur_req = "R8";
    nrz_mode = 1'b1;
    for (int i = 0; i < 80; i++) half(next_bit());
    los = 1'b1;
    for (int i = 0; i < 10; i++) half(1'b1);
    los = 1'b0;
    nrz_mode = 1'b0;

    cur_req = "R8 R5 R2";
    for (int i = 0; i < 100; i++) send_bit(next_bit(), 1'b0);

    cur_req = "R10 R1";
    do_reset();
    for (int i = 0; i < 40; i++) send_bit(1'b0, 1'b0);
    repeat (8) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule